// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers thirty-two peripheral interrupt sources into one interrupt request for the processor. Software sees two 32-bit registers through a small memory-mapped port: a status word that shows which sources are raised, and an enable word that selects which of them may interrupt. A source is pending when its status bit and its enable bit are both 1. The block raises a single registered request line and reports, next to it, the index of the lowest-numbered pending source together with a valid flag.

Most sources are level inputs and appear in the status word exactly as they arrive. Two sources, the serial transmit-complete and serial receive-complete events on inputs 10 and 11, are one-cycle pulses. The block captures these in sticky status bits that software clears by writing 1 to them. Writes to every other status position are dropped.

The request line comes from a two-state machine. `IRQ_QUIET` is the reset state and moves to `IRQ_RAISED` when any source is pending. `IRQ_RAISED` returns to `IRQ_QUIET` when nothing is pending. In every other case the state is held. The reported index is registered on the same edge as the state.

Top module: `pirq_aggregator`

## Requirements
- R1: After reset the enable word and the two sticky status bits are 0, `irq_out` and `irq_valid` are low and `irq_idx` is 0.
- R2: A write with `addr` = 0x4 loads all 32 bits of the enable word, and a read at 0x4 returns the stored value.
- R3: A read at offset 0x0 shows each status bit other than 10 and 11 equal to the live level of its `src_in` bit in that same cycle.
- R4: A one-cycle high pulse on `src_in[10]` or `src_in[11]` sets status bit 10 or 11 on the next clock edge. The bit stays set after the pulse ends.
- R5: A status write (offset 0x0) with data bit 10 or 11 at 1 clears that sticky bit. A 0 in that data bit leaves the sticky bit unchanged.
- R6: When a set pulse and a clearing write reach the same sticky bit in one cycle, the bit ends up set.
- R7: Writes to status bits other than 10 and 11 have no effect on the status word read back.
- R8: `irq_out` is high in a cycle exactly when (status AND enable) was nonzero in the cycle before.
- R9: When `irq_valid` is high, `irq_idx` gives the lowest bit position that was set in (status AND enable) in the cycle before.
- R10: When nothing was pending in the cycle before, `irq_valid` is low and `irq_idx` is 0.
- R11: A read at any offset other than 0x0 and 0x4 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 32 | Source inputs: levels, except bits 10 and 11, which are event pulses |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 4 | Register byte offset: 0x0 status, 0x4 enable |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_out | output | 1 | Combined interrupt request (registered) |
| irq_valid | output | 1 | `irq_idx` is meaningful |
| irq_idx | output | 5 | Lowest pending source index |

## Verification
The bench targets four corner cases. The first is a set pulse and a clearing write on the same sticky bit in one cycle; a design that gave the clear priority would lose that event. The second is an all-ones status write; a design that cleared or stored the wrong bits would let the level bits or both sticky bits change. The third is several sources pending together at both ends of the word, where a high-first encoder would report the wrong source. The fourth is the edge where pending falls to zero, where a design that kept a stale index or held the request would give a spurious interrupt.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_ENABLE = 4;
endpackage

// File: rtl/pirq_status_bank.sv
module pirq_status_bank #(
    parameter int unsigned        N_SRC   = 32,
    parameter logic [N_SRC-1:0]   EVT_SEL = 32'h0000_0C00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic             clr_wr,
    input  logic [N_SRC-1:0] clr_data,
    output logic [N_SRC-1:0] stat
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        if (EVT_SEL[i]) begin : g_sticky
            logic hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hold_q <= 1'b0;
                end else if (src_in[i]) begin
                    hold_q <= 1'b1;          // a new event beats a clear
                end else if (clr_wr && clr_data[i]) begin
                    hold_q <= 1'b0;
                end
            end
            assign stat[i] = hold_q;
        end else begin : g_level
            assign stat[i] = src_in[i];
        end
    end
endmodule

// File: rtl/pirq_enable_reg.sv
module pirq_enable_reg #(
    parameter int unsigned N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] enable
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (we) begin
            enable <= wdata;
        end
    end
endmodule

// File: rtl/pirq_low_first_enc.sv
module pirq_low_first_enc #(
    parameter int unsigned N_SRC = 32,
    localparam int unsigned IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |pend;
    end
endmodule

// File: rtl/pirq_aggregator.sv
module pirq_aggregator #(
    parameter int unsigned        N_SRC   = 32,
    parameter int unsigned        ADDR_W  = 4,
    parameter logic [N_SRC-1:0]   EVT_SEL = 32'h0000_0C00,
    localparam int unsigned       IDX_W   = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  wdata,
    output logic [N_SRC-1:0]  rdata,
    output logic              irq_out,
    output logic              irq_valid,
    output logic [IDX_W-1:0]  irq_idx
);
    import pirq_pkg::*;

    logic              sel_stat;
    logic              sel_en;
    logic [N_SRC-1:0]  stat_w;
    logic [N_SRC-1:0]  en_w;
    logic [N_SRC-1:0]  pend_w;
    logic              enc_any;
    logic [IDX_W-1:0]  enc_idx;
    irq_state_e        state_q;
    irq_state_e        state_d;
    logic [IDX_W-1:0]  idx_q;

    assign sel_stat = (addr == ADDR_W'(OFS_STATUS));
    assign sel_en   = (addr == ADDR_W'(OFS_ENABLE));

    pirq_status_bank #(.N_SRC(N_SRC), .EVT_SEL(EVT_SEL)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .clr_wr   (wr_en && sel_stat),
        .clr_data (wdata),
        .stat     (stat_w)
    );

    pirq_enable_reg #(.N_SRC(N_SRC)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en && sel_en),
        .wdata  (wdata),
        .enable (en_w)
    );

    assign pend_w = stat_w & en_w;

    pirq_low_first_enc #(.N_SRC(N_SRC)) u_enc (
        .pend (pend_w),
        .any  (enc_any),
        .idx  (enc_idx)
    );

    always_comb begin
        if (sel_stat)    rdata = stat_w;
        else if (sel_en) rdata = en_w;
        else             rdata = '0;
    end

    // request state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (enc_any)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!enc_any) state_d = IRQ_QUIET;
            default:                  state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= '0;
        else if (enc_any) idx_q <= enc_idx;
        else              idx_q <= '0;
    end

    assign irq_out   = (state_q == IRQ_RAISED);
    assign irq_valid = (state_q == IRQ_RAISED);
    assign irq_idx   = idx_q;
endmodule

module pirq_aggregator_chk #(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_in,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N_SRC-1:0]  wdata,
    input logic [N_SRC-1:0]  stat_w,
    input logic [N_SRC-1:0]  en_w,
    input logic [N_SRC-1:0]  pend_w,
    input logic              irq_out,
    input logic              irq_valid,
    input logic [IDX_W-1:0]  irq_idx
);
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4)) |=> (en_w == $past(wdata)));

    a_r4_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        src_in[10] |=> stat_w[10]);

    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && wdata[11] && !src_in[11]) |=> !stat_w[11]);

    a_r5_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w[10] && !(wr_en && addr == ADDR_W'(0) && wdata[10])) |=> stat_w[10]);

    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_w) |=> irq_out);

    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend_w) |=> !irq_out);

    a_r9_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_w) |=> ((($past(pend_w) >> irq_idx) & 1) == 1));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_idx == '0));
endmodule

bind pirq_aggregator pirq_aggregator_chk #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .stat_w    (stat_w),
    .en_w      (en_w),
    .pend_w    (pend_w),
    .irq_out   (irq_out),
    .irq_valid (irq_valid),
    .irq_idx   (irq_idx)
);

// File: tb/pirq_aggregator_test.sv
module pirq_aggregator_test;
    localparam logic [31:0] EVT = 32'h0000_0C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;
    logic        irq_valid;
    logic [4:0]  irq_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_sticky = '0;
    logic [31:0] m_en = '0;
    logic        e_irq = 1'b0;
    logic [4:0]  e_idx = '0;

    always #4 clk = ~clk;

    pirq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
        .irq_valid(irq_valid), .irq_idx(irq_idx)
    );

    function automatic logic [31:0] stat_of(input logic [31:0] live);
        return (live & ~EVT) | m_sticky;
    endfunction

    function automatic logic [31:0] read_of(input logic [3:0] a, input logic [31:0] live);
        if (a == 4'h0) return stat_of(live);
        if (a == 4'h4) return m_en;
        return '0;
    endfunction

    function automatic logic [4:0] low_idx(input logic [31:0] p);
        for (int i = 31; i >= 0; i--) if (p[i]) low_idx = 5'(i);
        if (p == '0) low_idx = '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] live, input logic we, input logic [3:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] p;
        @(negedge clk);
        chk("R8 irq_out", {31'd0, irq_out}, {31'd0, e_irq});
        chk(e_irq ? "R9 irq_valid" : "R10 irq_valid", {31'd0, irq_valid}, {31'd0, e_irq});
        chk(e_irq ? "R9 irq_idx" : "R10 irq_idx", {27'd0, irq_idx}, {27'd0, e_idx});
        src_in = live; wr_en = we; addr = a; wdata = d;
        #1;
        chk(tag, rdata, read_of(a, live));
        p = stat_of(live) & m_en;
        @(posedge clk);
        e_irq = |p;
        e_idx = low_idx(p);
        if (we && a == 4'h0) m_sticky = m_sticky & ~(d & EVT);
        m_sticky = m_sticky | (live & EVT);
        if (we && a == 4'h4) m_en = d;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] live;
        logic [3:0]  a;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents
        step('0, 0, 4'h0, '0, "R1 status");
        step('0, 0, 4'h4, '0, "R1 enable");
        // R11: unmapped offsets
        step('1 & ~EVT, 0, 4'h8, '0, "R11 off8");
        step('1 & ~EVT, 0, 4'hC, '0, "R11 offC");
        // R3: live levels
        step(32'hA5A5_0321, 0, 4'h0, '0, "R3 live");
        // R2: enable register
        step('0, 1, 4'h4, 32'hFFFF_FFFF, "R2 write");
        step('0, 0, 4'h4, '0, "R2 read ones");
        step('0, 1, 4'h4, 32'h1234_5678, "R2 write");
        step('0, 0, 4'h4, '0, "R2 read pattern");
        step('0, 1, 4'h4, '0, "R2 clear");
        // R4: pulse latched
        step(32'h0000_0400, 0, 4'h0, '0, "R4 pulse");
        step('0, 0, 4'h0, '0, "R4 held");
        step('0, 0, 4'h0, '0, "R4 held");
        // R7: non-event write ignored
        step(32'h8000_0001, 1, 4'h0, 32'hFFFF_F3FF, "R7 write");
        step(32'h8000_0001, 0, 4'h0, '0, "R7 unchanged");
        // R5: write zero then write one
        step(32'h0000_0800, 0, 4'h0, '0, "R4 pulse11");
        step('0, 1, 4'h0, 32'h0000_0000, "R5 zero write");
        step('0, 0, 4'h0, '0, "R5 kept");
        step('0, 1, 4'h0, 32'h0000_0400, "R5 clear10");
        step('0, 0, 4'h0, '0, "R5 only10 cleared");
        // R6: set and clear together
        step(32'h0000_0800, 1, 4'h0, 32'h0000_0800, "R6 collide");
        step('0, 0, 4'h0, '0, "R6 set wins");
        step('0, 1, 4'h0, 32'hFFFF_FFFF, "R7 all ones");
        step('0, 0, 4'h0, '0, "R7 after all ones");
        // R8 R9 R10: priority and idle
        step('0, 1, 4'h4, 32'hFFFF_FFFF, "R2 enable all");
        step(32'h0010_0008, 0, 4'h0, '0, "R9 two pending");
        step(32'h8000_0000, 0, 4'h0, '0, "R9 top bit");
        step(32'h0000_0001, 0, 4'h0, '0, "R9 bit0");
        step('0, 0, 4'h0, '0, "R10 drain");
        step('0, 0, 4'h0, '0, "R10 idle");
        step(32'h0000_0400, 0, 4'h0, '0, "R8 event irq");
        step('0, 0, 4'h0, '0, "R8 event held");
        step('0, 1, 4'h4, 32'h0000_0001, "R8 masked");
        step('0, 0, 4'h0, '0, "R10 masked idle");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            live = $urandom() & $urandom() & $urandom();
            if (($urandom() % 4) != 0) live = live & ~EVT;
            a = 4'(($urandom() % 4) * 4);
            step(live, ($urandom() % 3) == 0, a, $urandom() & $urandom(), "R3 R7 random read");
        end
        step('0, 1, 4'h4, '0, "R2 final");
        step('0, 0, 4'h0, '0, "R10 final");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule